// File: doc/BRIEF.md
# Double-Buffered Clock-Enable Divider Bank

This block runs fourteen small integer dividers from one fast clock, seven for each of two display channels, and drives one clock-enable pulse per divider. The downstream pixel, encoder and interface logic stays on the fast clock and acts only on cycles where its enable is high. Each ratio is set by a 3-bit field. The fields are spread over two 32-bit registers on a simple word-wide register port.

Software writes land only in a staging copy. The running dividers see nothing until a commit. A commit happens when the update flag, bit 31 of the parameter register, goes from 0 to 1. The usual sequence is to clear the flag, write the fields, and then set the flag. On a commit all fourteen staged fields move into the active set together. Each divider picks up its new ratio at the end of its current period, so no enable interval is cut short or doubled. Reads always return the staged copy.

Top module: `clkdiv_bank`

## Requirements
- R1: Output `tick_en[c*7+k]` belongs to channel c (0 or 1) and kind k, in this order: 0 VGA, 1 picture, 2 TV encoder, 3 HDMI PNX, 4 HDMI, 5 interface, 6 layer. Kinds 0 and 1 live in the select register (`reg_addr`=0), with the 3-bit field at bit c*6+k*3.
- R2: Kinds 2 to 6 live in the parameter register (`reg_addr`=1), with the 3-bit field at bit c*15+(k-2)*3. The update flag is bit 31 of that register.
- R3: A register write changes only the staged values. The enable outputs keep their existing ratios until a commit.
- R4: A 0-to-1 transition of the update flag copies all fourteen staged fields into the active set one cycle after the write.
- R5: A parameter write with bit 31 set while the flag is already 1 causes no commit. New staged values take effect only after the flag is cleared and set again.
- R6: A divider with active field value v drives its enable high for exactly one cycle in every v+1 cycles, so ratios run from 1 to 8.
- R7: A new active value is taken up only at the divider's wrap, which is the cycle its enable is high. The interval that ends at that wrap keeps the old length.
- R8: After synchronous reset, every field and the update flag are 0 and every enable is high on every cycle.
- R9: A read returns the staged fields and the flag at the bit positions of R1 and R2. Unused bits read 0. The read data follows `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Word write strobe |
| reg_addr | input | 1 | Register select: 0 select register, 1 parameter register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Staged contents of the selected register |
| tick_en | output | 14 | One clock-enable per divider |

## Verification
The checker assumes the write strobe and the data on the register port are fully defined on every clock after reset. It also assumes reset is held for at least two edges, so that its one-cycle history never reaches back into undefined values. The stimulus changes inputs only just after a rising edge, holds reset for several cycles, and drives every port to a known value from time zero. Commits are spaced far enough apart that each divider can wrap and show its new interval, and they are also issued while dividers are mid-count, so the wrap-only loading is exercised.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PER_CH     = 7;
    localparam int SEL_PER_CH = 2;
    localparam int PAR_PER_CH = PER_CH - SEL_PER_CH;

    typedef enum logic [2:0] {
        K_VGA   = 3'd0,
        K_PIC   = 3'd1,
        K_TVE   = 3'd2,
        K_PNX   = 3'd3,
        K_HDMI  = 3'd4,
        K_INTF  = 3'd5,
        K_LAYER = 3'd6
    } div_kind_e;

    typedef enum logic {
        REG_SEL = 1'b0,
        REG_PAR = 1'b1
    } reg_sel_e;

    function automatic reg_sel_e reg_of(input int kind);
        return (kind < SEL_PER_CH) ? REG_SEL : REG_PAR;
    endfunction

    function automatic int lsb_of(input int ch, input int kind, input int fw);
        if (kind < SEL_PER_CH)
            return ch * SEL_PER_CH * fw + kind * fw;
        return ch * PAR_PER_CH * fw + (kind - SEL_PER_CH) * fw;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int CH_N = 2,
    parameter int FW   = 3,
    parameter int DW   = 32,
    localparam int NDIV = CH_N * PER_CH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic                      addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    output logic [NDIV-1:0][FW-1:0]   active_o,
    output logic                      flag_o,
    output logic                      commit_o
);

    logic [FW-1:0] stage_q  [NDIV];
    logic [FW-1:0] active_q [NDIV];
    logic          flag_q;
    logic          flag_d1;
    logic          commit;

    for (genvar d = 0; d < NDIV; d++) begin : g_stage
        localparam int       CH  = d / PER_CH;
        localparam int       K   = d % PER_CH;
        localparam reg_sel_e R   = reg_of(K);
        localparam int       LSB = lsb_of(CH, K, FW);

        always_ff @(posedge clk) begin
            if (rst)
                stage_q[d] <= '0;
            else if (wr && (addr == R))
                stage_q[d] <= wdata[LSB +: FW];
        end

        assign active_o[d] = active_q[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            flag_d1 <= 1'b0;
        end else begin
            flag_d1 <= flag_q;
            if (wr && (addr == REG_PAR))
                flag_q <= wdata[DW-1];
        end
    end

    assign commit = flag_q & ~flag_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NDIV; d++) active_q[d] <= '0;
        end else if (commit) begin
            for (int d = 0; d < NDIV; d++) active_q[d] <= stage_q[d];
        end
    end

    logic [DW-1:0] rd_sel;
    logic [DW-1:0] rd_par;

    always_comb begin
        rd_sel = '0;
        rd_par = '0;
        for (int d = 0; d < NDIV; d++) begin
            if (reg_of(d % PER_CH) == REG_SEL)
                rd_sel[lsb_of(d / PER_CH, d % PER_CH, FW) +: FW] = stage_q[d];
            else
                rd_par[lsb_of(d / PER_CH, d % PER_CH, FW) +: FW] = stage_q[d];
        end
        rd_par[DW-1] = flag_q;
    end

    assign rdata    = (addr == REG_PAR) ? rd_par : rd_sel;
    assign flag_o   = flag_q;
    assign commit_o = commit;

endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit #(
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] next_val,
    output logic          tick,
    output logic [FW-1:0] cnt_o,
    output logic [FW-1:0] cur_o
);

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] cur_q;
    logic          wrap;

    assign wrap = (cnt_q == cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            cur_q <= next_val;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick  = wrap;
    assign cnt_o = cnt_q;
    assign cur_o = cur_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int CH_N = 2,
    parameter int FW   = 3,
    parameter int DW   = 32,
    localparam int NDIV = CH_N * PER_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NDIV-1:0] tick_en
);

    logic [NDIV-1:0][FW-1:0] active;
    logic [NDIV-1:0][FW-1:0] cnt_all;
    logic [NDIV-1:0][FW-1:0] cur_all;
    logic                    flag;
    logic                    commit;

    clkdiv_regs #(.CH_N(CH_N), .FW(FW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .active_o (active),
        .flag_o   (flag),
        .commit_o (commit)
    );

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        clkdiv_unit #(.FW(FW)) u_div (
            .clk      (clk),
            .rst      (rst),
            .next_val (active[d]),
            .tick     (tick_en[d]),
            .cnt_o    (cnt_all[d]),
            .cur_o    (cur_all[d])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NDIV = 14,
    parameter int FW   = 3,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_wr,
    input logic                    reg_addr,
    input logic [DW-1:0]           reg_wdata,
    input logic [NDIV-1:0]         tick_en,
    input logic                    flag,
    input logic                    commit,
    input logic [NDIV-1:0][FW-1:0] active,
    input logic [NDIV-1:0][FW-1:0] cnt_all,
    input logic [NDIV-1:0][FW-1:0] cur_all
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    assert_reset_ticks_R8: assert property (@(posedge clk)
        rst |=> (tick_en == {NDIV{1'b1}}));

    assert_hold_active_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        !commit |=> $stable(active));

    assert_commit_rise_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (reg_wr && reg_addr && reg_wdata[DW-1] && !flag) |=> commit);

    assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (reg_wr && reg_addr && reg_wdata[DW-1] && flag) |=> !commit);

    for (genvar d = 0; d < NDIV; d++) begin : g_per
        assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst || !armed)
            cnt_all[d] <= cur_all[d]);

        assert_load_at_wrap_R7: assert property (@(posedge clk) disable iff (rst || !armed)
            (cur_all[d] != $past(cur_all[d])) |-> $past(tick_en[d]));
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NDIV(NDIV), .FW(FW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick_en   (tick_en),
    .flag      (flag),
    .commit    (commit),
    .active    (active),
    .cnt_all   (cnt_all),
    .cur_all   (cur_all)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;

    localparam int ND = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [ND-1:0] tick_en;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    clkdiv_bank i_clkdiv_bank (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_en   (tick_en)
    );

    // reference model state
    int mcnt [ND];
    int mcur [ND];
    int mact [ND];
    int mstg [ND];
    int mflag = 0;
    int mflagp = 0;
    int vals [ND];

    initial begin
        for (int d = 0; d < ND; d++) begin
            mcnt[d] = 0; mcur[d] = 0; mact[d] = 0; mstg[d] = 0; vals[d] = 0;
        end
    end

    function automatic int fld_reg(int d);
        return ((d % 7) < 2) ? 0 : 1;
    endfunction

    function automatic int fld_pos(int d);
        int c = d / 7;
        int k = d % 7;
        if (k < 2) return c * 6 + k * 3;
        return c * 15 + (k - 2) * 3;
    endfunction

    function automatic logic [31:0] word_of(int r, int flag_bit, int src [ND]);
        logic [31:0] w = '0;
        for (int d = 0; d < ND; d++)
            if (fld_reg(d) == r) w = w | (32'(src[d] & 7) << fld_pos(d));
        if (r == 1 && flag_bit != 0) w[31] = 1'b1;
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < ND; d++) begin
                mcnt[d] = 0; mcur[d] = 0; mact[d] = 0; mstg[d] = 0;
            end
            mflag = 0; mflagp = 0;
        end else begin
            for (int d = 0; d < ND; d++) begin
                if (mcnt[d] == mcur[d]) begin
                    mcnt[d] = 0; mcur[d] = mact[d];
                end else mcnt[d] = mcnt[d] + 1;
            end
            if (mflag == 1 && mflagp == 0)
                for (int d = 0; d < ND; d++) mact[d] = mstg[d];
            mflagp = mflag;
            if (reg_wr) begin
                for (int d = 0; d < ND; d++)
                    if (fld_reg(d) == int'(reg_addr)) mstg[d] = int'((reg_wdata >> fld_pos(d)) & 32'd7);
                if (reg_addr) mflag = int'(reg_wdata[31]);
            end
        end
    end

    // per-cycle comparison against the model (R6, R7, R9)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [ND-1:0] exp_t;
            logic [31:0] exp_r;
            for (int d = 0; d < ND; d++) exp_t[d] = (mcnt[d] == mcur[d]);
            exp_r = word_of(int'(reg_addr), mflag, mstg);
            n_run++;
            if (tick_en !== exp_t) begin
                n_fail++;
                $display("FAIL R6 R7 cycle enables: got %b expected %b", tick_en, exp_t);
            end
            n_run++;
            if (reg_rdata !== exp_r) begin
                n_fail++;
                $display("FAIL R9 cycle readback: got %h expected %h", reg_rdata, exp_r);
            end
        end
    end

    task automatic check(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] dat);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dat;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic measure(input int idx, output int n);
        @(negedge clk);
        while (!tick_en[idx]) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_en[idx] && n < 20);
    endtask

    task automatic read_word(input logic a, output logic [31:0] w);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        w = reg_rdata;
    endtask

    task automatic check_ratios(string tag, int src [ND]);
        int n;
        for (int d = 0; d < ND; d++) begin
            measure(d, n);
            check($sformatf("%s divider %0d interval", tag, d), n, src[d] + 1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] w;
        int n;
        int set_a [ND];
        int set_b [ND];
        int ones [ND];
        for (int d = 0; d < ND; d++) begin
            set_a[d] = (d + 3) % 8;
            set_b[d] = (d * 5 + 2) % 8;
            ones[d]  = 0;
        end

        idle(4);
        rst = 1'b0;
        idle(1);

        // R8: reset state
        read_word(1'b0, w); check("R8 select reg after reset", int'(w), 0);
        read_word(1'b1, w); check("R8 param reg after reset", int'(w), 0);
        measure(0, n);  check("R8 ratio one after reset ch0", n, 1);
        measure(13, n); check("R8 ratio one after reset ch1", n, 1);

        // stage set A with flag clear: no effect on outputs (R3)
        wr(1'b1, word_of(1, 0, set_a));
        wr(1'b0, word_of(0, 0, set_a));
        idle(12);
        check_ratios("R3 staged only", ones);

        // R1, R2, R9: readback layout
        read_word(1'b0, w); check("R1 R9 select layout", int'(w), int'(word_of(0, 0, set_a)));
        read_word(1'b1, w); check("R2 R9 param layout", int'(w), int'(word_of(1, 0, set_a)));

        // commit (R4) and ratios (R6, incl. 1 and 8)
        wr(1'b1, word_of(1, 1, set_a));
        idle(12);
        check_ratios("R4 R6 after commit A", set_a);

        // stage set B while flag is high (R5)
        wr(1'b1, word_of(1, 1, set_b));
        wr(1'b0, word_of(0, 0, set_b));
        idle(12);
        check_ratios("R5 no commit while flag high", set_a);
        read_word(1'b1, w); check("R9 staged not active", int'(w), int'(word_of(1, 1, set_b)));

        // clear then set: B takes effect mid-count (R4, R7 via cycle model)
        wr(1'b1, word_of(1, 0, set_b));
        idle(3);
        wr(1'b1, word_of(1, 1, set_b));
        idle(12);
        check_ratios("R4 R7 after recommit B", set_b);

        // back to ratio 1 everywhere, committed in one go
        wr(1'b1, word_of(1, 0, ones));
        wr(1'b0, word_of(0, 0, ones));
        wr(1'b1, word_of(1, 1, ones));
        idle(12);
        check_ratios("R6 ratio one restored", ones);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule